// File: doc/BRIEF.md
# Serial PHY management master

This block runs the management side of a two-wire PHY register bus: one clock that the master generates and one shared data line. A host asks for a transfer with a one-cycle start pulse, a read or write select, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block builds the whole frame and sends it. It drives the management clock, the outgoing data bit and an output-enable for the shared line, and it reads the incoming data bit.

On a read, the block lets go of the line after the register address. It checks whether any PHY answers. It always clocks the full data phase, so every PHY on the bus stays aligned with the frame even when nobody answered. The host sees a busy level for the length of the frame. A single-cycle done pulse ends the frame, and the read result and the no-answer flag are valid when done is high.

The management clock period is set by a parameter that gives the number of system cycles in each clock half. The default gives 2.5 MHz from a 50 MHz system clock.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no transfer is running, `mdc_o` is low, `oe_o` is low and `busy_o` is low.
- R2: A transfer begins with 32 management clock pulses during which `oe_o` is high and `mdo_o` is 1.
- R3: After the preamble the block sends the start pattern 0 then 1, followed by the operation code: 1 then 0 for a read (`rd_i`=1), 0 then 1 for a write (`rd_i`=0).
- R4: The 5-bit PHY address comes next, then the 5-bit register address. Every field is sent most significant bit first, and one bit is sent per management clock pulse, valid at its rising edge.
- R5: A write then sends the turnaround pattern 1 then 0, then the 16 data bits most significant bit first, then one idle pulse with `mdo_o`=1. `oe_o` stays high for all 65 pulses and falls when the frame ends.
- R6: A read drives `oe_o` only for the first 46 pulses. Pulse 47 is the turnaround. The level of `mdi_i` before the rising edge of pulse 48 is the acknowledge: low means a PHY answered.
- R7: On an acknowledged read, `mdi_i` is sampled in the last system cycle before the rising edges of pulses 49 to 64. These bits form `rdata_o` most significant bit first. One trailing idle pulse follows, for 65 pulses in total.
- R8: If the acknowledge is high, the block still gives all 65 pulses, then sets `err_o` to 1 and `rdata_o` to 0. A transfer that gets an acknowledge, and any write, leaves `err_o` at 0.
- R9: Every high and every low half of `mdc_o` lasts at least `HALF_DIV` system clock cycles.
- R10: `busy_o` is high from the cycle after an accepted start until the frame ends. A start pulse while busy has no effect on the frame being sent or on its result.
- R11: `done_o` is high for exactly one cycle per frame. In that cycle `busy_o` has just fallen, and `rdata_o` and `err_o` hold the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to start a transfer |
| rd_i | input | 1 | 1 selects read, 0 selects write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read result |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| err_o | output | 1 | No PHY acknowledged the last read |
| busy_o | output | 1 | Transfer in progress |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Outgoing data bit |
| oe_o | output | 1 | Output enable for the shared data line |
| mdi_i | input | 1 | Incoming data bit |

## Verification
A bench PHY model counts management clock edges. It logs the outgoing bit and the enable at every rising edge, and it drives the acknowledge and read data in the low halves that come before the sampling edges. Random reads and writes with random addresses and data, about one read in five left unacknowledged, check that every field lands in its own bit window. Directed cases fill in what random draws might miss. Data patterns with only the top and bottom bits set catch a reversed or shifted capture. An unanswered read whose PHY model still offers data shows whether that data leaks through. A second start pulse in the middle of a frame, with different fields, would corrupt the logged frame or add a done pulse if it were accepted.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic {OP_WR = 1'b0, OP_RD = 1'b1} mdio_op_e;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OPC_RD    = 2'b10;
  localparam logic [1:0] OPC_WR    = 2'b01;
  localparam logic [1:0] TA_WR     = 2'b10;
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
  parameter int HALF_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic half_end_o
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign half_end_o = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (half_end_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         mdo_o
);
  logic [W-1:0] sr_q;

  assign mdo_o = sr_q[W-1];

  // ones shift in, so the line idles high after the last field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '1;
    else if (load_i)  sr_q <= load_val_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b1};
  end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              ack_stb_i,
  input  logic              bit_stb_i,
  input  logic              mdi_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  logic [DATA_W-1:0] data_q;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (clear_i) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (ack_stb_i) err_q <= mdi_i;
      // data is not captured without an acknowledge
      if (bit_stb_i && !err_q) data_q <= {data_q[DATA_W-2:0], mdi_i};
    end
  end

  assign rdata_o = data_q;
  assign err_o   = err_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 10,
  parameter int PRE_LEN  = 32,
  parameter int PHY_AW   = 5,
  parameter int REG_AW   = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o,
  output logic              mdc_o,
  output logic              mdo_o,
  output logic              oe_o,
  input  logic              mdi_i
);
  // bit positions within the frame, counted from 0
  localparam int ADDR_END   = PRE_LEN + 4 + PHY_AW + REG_AW; // bits driven on a read
  localparam int ACK_IDX    = ADDR_END + 1;
  localparam int DATA_FIRST = ACK_IDX + 1;
  localparam int DATA_LAST  = DATA_FIRST + DATA_W - 1;
  localparam int LAST_IDX   = DATA_LAST + 1;                 // trailing idle bit
  localparam int SR_W       = LAST_IDX;
  localparam int IDX_W      = $clog2(LAST_IDX + 1);
  localparam int RD_TAIL    = SR_W - ADDR_END;

  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(LAST_IDX);
  localparam logic [IDX_W-1:0] IDX_REL    = IDX_W'(ADDR_END - 1);
  localparam logic [IDX_W-1:0] IDX_ACK    = IDX_W'(ACK_IDX);
  localparam logic [IDX_W-1:0] IDX_DFIRST = IDX_W'(DATA_FIRST);
  localparam logic [IDX_W-1:0] IDX_DLAST  = IDX_W'(DATA_LAST);

  logic             busy_q, phase_q, mdc_q, oe_q, done_q;
  logic [IDX_W-1:0] idx_q;
  mdio_op_e         op_q;
  logic             half_end, accept;
  logic [SR_W-1:0]  frame_w;

  assign accept = start_i && !busy_q;

  mdio_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (busy_q),
    .half_end_o (half_end)
  );

  always_comb begin
    if (rd_i)
      frame_w = {{PRE_LEN{1'b1}}, START_PAT, OPC_RD, phy_addr_i, reg_addr_i,
                 {RD_TAIL{1'b1}}};
    else
      frame_w = {{PRE_LEN{1'b1}}, START_PAT, OPC_WR, phy_addr_i, reg_addr_i,
                 TA_WR, wdata_i};
  end

  mdio_tx_shift #(.W(SR_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (frame_w),
    .shift_i    (half_end && phase_q && (idx_q != IDX_LAST)),
    .mdo_o      (mdo_o)
  );

  logic rd_low_end;
  assign rd_low_end = half_end && !phase_q && (op_q == OP_RD);

  mdio_rx_capture #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept),
    .ack_stb_i (rd_low_end && (idx_q == IDX_ACK)),
    .bit_stb_i (rd_low_end && (idx_q >= IDX_DFIRST) && (idx_q <= IDX_DLAST)),
    .mdi_i     (mdi_i),
    .rdata_o   (rdata_o),
    .err_o     (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      mdc_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      op_q    <= OP_WR;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          phase_q <= 1'b0;
          idx_q   <= '0;
          oe_q    <= 1'b1;
          op_q    <= rd_i ? OP_RD : OP_WR;
        end
      end else if (half_end) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
          mdc_q   <= 1'b1;
        end else begin
          mdc_q <= 1'b0;
          if (idx_q == IDX_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            oe_q   <= 1'b0;
          end else begin
            idx_q   <= idx_q + 1'b1;
            phase_q <= 1'b0;
            if (op_q == OP_RD && idx_q == IDX_REL) oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign mdc_o  = mdc_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_DIV = 10,
  parameter int DATA_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              mdc_o,
  input logic              oe_o
);
  localparam int HW = $clog2(HALF_DIV + 2);
  localparam logic [HW-1:0] HMAX = HW'(HALF_DIV + 1);

  logic          mdc_prev_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_prev_q <= 1'b0;
      hold_q     <= HMAX;
    end else begin
      mdc_prev_q <= mdc_o;
      if (mdc_o != mdc_prev_q) hold_q <= HW'(1);
      else if (hold_q != HMAX) hold_q <= hold_q + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !oe_o));

  p_half_period_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o != mdc_prev_q) |-> (hold_q >= HW'(HALF_DIV)));

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (rdata_o == '0));
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .rdata_o (rdata_o),
  .mdc_o   (mdc_o),
  .oe_o    (oe_o)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF_DIV = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, rd_i = 1'b0;
  logic [4:0]  phy_addr_i = '0, reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        done_o, err_o, busy_o, mdc_o, mdo_o, oe_o, mdi_i;

  int checks = 0, fails = 0;

  always #10 clk_i = ~clk_i;

  mdio_master u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rd_i(rd_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .done_o(done_o), .err_o(err_o), .busy_o(busy_o),
    .mdc_o(mdc_o), .mdo_o(mdo_o), .oe_o(oe_o), .mdi_i(mdi_i)
  );

  // PHY model: rise_cnt equals the index of the bit in its low half
  int          rise_cnt = 0;
  logic [64:0] mdo_log = '0, oe_log = '0;
  logic        phy_nack = 1'b0;
  logic [15:0] phy_data = '0;

  assign mdi_i = (rise_cnt == 47) ? phy_nack :
                 (rise_cnt >= 48 && rise_cnt <= 63) ? phy_data[63 - rise_cnt] : 1'b1;

  always @(posedge mdc_o) begin
    if (rise_cnt < 65) begin
      mdo_log[64 - rise_cnt] <= mdo_o;
      oe_log[64 - rise_cnt]  <= oe_o;
    end
    rise_cnt <= rise_cnt + 1;
  end

  int done_cnt = 0, hold = 0, min_hold = 1000;
  logic mdc_prev = 1'b0;
  always @(posedge clk_i) begin
    if (done_o) done_cnt++;
    if (mdc_o != mdc_prev) begin
      if (hold < min_hold) min_hold = hold;
      hold = 1;
    end else hold++;
    mdc_prev = mdc_o;
  end

  task automatic check(input logic ok, input string req, input logic [64:0] act,
                       input logic [64:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [64:0] exp_frame(input logic rd, input logic [4:0] pa,
                                            input logic [4:0] ra, input logic [15:0] wd);
    if (rd) return {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 19'h0};
    return {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd, 1'b1};
  endfunction

  function automatic logic [64:0] exp_oe(input logic rd);
    if (rd) return {{46{1'b1}}, 19'h0};
    return {65{1'b1}};
  endfunction

  task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic nack, input logic [15:0] pd,
                         input logic inject);
    logic [64:0] ef, eo;
    logic [15:0] exp_rd;
    int          d0, w;
    ef = exp_frame(rd, pa, ra, wd);
    eo = exp_oe(rd);
    exp_rd = (rd && !nack) ? pd : 16'h0;
    phy_nack = nack;
    phy_data = pd;
    rise_cnt = 0;
    mdo_log = '0;
    oe_log = '0;
    d0 = done_cnt;
    @(negedge clk_i);
    start_i = 1'b1; rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R10 busy after start", 65'(busy_o), 65'd1);
    if (inject) begin
      repeat (300) @(negedge clk_i);
      start_i = 1'b1; rd_i = ~rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    w = 0;
    while (done_o !== 1'b1 && w < 3000) begin
      @(negedge clk_i);
      w++;
    end
    check(done_o === 1'b1, "R11 done seen", 65'(done_o), 65'd1);
    check(busy_o === 1'b0, "R11 busy low with done", 65'(busy_o), 65'd0);
    if (rd) begin
      check(err_o === nack, "R8 err flag", 65'(err_o), 65'(nack));
      check(rdata_o === exp_rd, nack ? "R8 zero data" : "R7 read data",
            65'(rdata_o), 65'(exp_rd));
    end else begin
      check(err_o === 1'b0, "R8 err clear on write", 65'(err_o), 65'd0);
    end
    @(negedge clk_i);
    check(done_o === 1'b0, "R11 done one cycle", 65'(done_o), 65'd0);
    check(mdc_o === 1'b0 && oe_o === 1'b0, "R1 idle lines", {63'd0, mdc_o, oe_o}, 65'd0);
    check(rise_cnt == 65, rd ? "R7 pulse count" : "R5 pulse count",
          65'(rise_cnt), 65'd65);
    check(done_cnt - d0 == 1, "R10 single done", 65'(done_cnt - d0), 65'd1);
    check(oe_log === eo, rd ? "R6 enable window" : "R5 enable window", oe_log, eo);
    check(mdo_log[64:33] === ef[64:33], "R2 preamble", 65'(mdo_log[64:33]), 65'(ef[64:33]));
    check(mdo_log[32:29] === ef[32:29], "R3 start and opcode",
          65'(mdo_log[32:29]), 65'(ef[32:29]));
    check(mdo_log[28:19] === ef[28:19], "R4 addresses", 65'(mdo_log[28:19]), 65'(ef[28:19]));
    if (!rd)
      check(mdo_log[18:0] === ef[18:0], "R5 turnaround data idle",
            65'(mdo_log[18:0]), 65'(ef[18:0]));
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check(mdc_o === 1'b0 && oe_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
          "R1 reset state", {61'd0, mdc_o, oe_o, busy_o, done_o}, 65'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(mdc_o === 1'b0 && oe_o === 1'b0 && busy_o === 1'b0,
          "R1 idle after reset", {62'd0, mdc_o, oe_o, busy_o}, 65'd0);

    // directed corner cases
    run_txn(1'b0, 5'h1F, 5'h00, 16'hFFFF, 1'b0, 16'h0, 1'b0);
    run_txn(1'b0, 5'h00, 5'h1F, 16'h0000, 1'b0, 16'h0, 1'b0);
    run_txn(1'b1, 5'h01, 5'h10, 16'h0, 1'b0, 16'h8001, 1'b0);
    run_txn(1'b1, 5'h0A, 5'h15, 16'h0, 1'b1, 16'hFFFF, 1'b0);
    run_txn(1'b1, 5'h0A, 5'h15, 16'h0, 1'b0, 16'h7FFE, 1'b0);
    run_txn(1'b0, 5'h12, 5'h04, 16'hA5C3, 1'b0, 16'h0, 1'b1);
    run_txn(1'b1, 5'h03, 5'h02, 16'h0, 1'b0, 16'h1234, 1'b1);

    for (int i = 0; i < 30; i++) begin
      logic rd, nack;
      rd = 1'($urandom);
      nack = ($urandom % 5) == 0;
      run_txn(rd, 5'($urandom), 5'($urandom), 16'($urandom), nack, 16'($urandom), 1'b0);
    end

    check(min_hold >= HALF_DIV, "R9 half period", 65'(min_hold), 65'(HALF_DIV));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule